// File: doc/BRIEF.md
# Non-Restoring Iterative Divider

This block divides an unsigned double-width dividend by an unsigned single-width divisor and produces a single-width quotient and remainder. It uses non-restoring division. A sign-extended partial remainder and the quotient register shift left together, one bit per clock. The divisor is then subtracted or added according to the sign left by the previous step. The new quotient bit is the inverse of the resulting sign. No value is restored inside the loop. One correcting addition runs after the last step, and only if the partial remainder is still negative.

A caller presents the operands with a one-cycle `start` pulse and waits for the one-cycle `done` pulse. The results and flags then stay on the outputs until the next accepted start. Two cases finish at once without iterating: a zero divisor, and a dividend whose upper half is not smaller than the divisor. In both cases the quotient would not fit in the output.

Top module: `nr_divider`

## Requirements
- R1: After reset, `done`, `quotient`, `remainder`, `divByZero` and `overflow` are all 0.
- R2: With a nonzero divisor and upper dividend half (`dividend[2W-1:W]`) below it, `quotient` = floor(dividend / divisor) and `remainder` = dividend mod divisor.
- R3: With a nonzero divisor not greater than the upper dividend half, `overflow` is 1 and `divByZero` is 0. `quotient` is all ones and `remainder` equals the upper dividend half.
- R4: With a zero divisor, `divByZero` is 1 and `overflow` is 0. `quotient` is all ones and `remainder` equals the upper dividend half.
- R5: `done` is high in the cycle after the start edge for R3/R4 cases. Otherwise it is high W clock edges after the start edge when the quotient's bit 0 is 1 (no correction), and W+1 edges after it when bit 0 is 0 (one correction cycle).
- R6: `done` is high for exactly one cycle per accepted start.
- R7: `start` is ignored from the edge that accepts a start until `done` has been high; operands presented meanwhile do not change the results.
- R8: After `done`, `quotient`, `remainder` and both flags hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; sampled only when idle |
| dividend | input | 2*W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient result |
| remainder | output | W | Remainder result |
| divByZero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient would not fit in W bits |

## Verification
A division that iterates finishes W or W+1 clock edges after the edge that samples `start`. The extra edge appears exactly when the quotient's bit 0 is 0, and the bench derives the expected count from its own quotient computed with integer arithmetic. The R3 and R4 cases must show `done` in the first cycle after the start edge. The bench drives inputs on falling edges and counts falling edges from the start edge until `done` is seen, so each result and the latency are sampled in the very cycle they are due. The bench then confirms that `done` has dropped one cycle later and that the outputs are unchanged several cycles after that.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic fix;
  } nrdivStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_FIN  = 2'd3
  } nrdivState_t;
endpackage

// File: rtl/nrdiv_datapath.sv
module nrdiv_datapath
  import nrdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  nrdivStrb_t       strb,
  input  logic [2*W-1:0]   dividend,
  input  logic [W-1:0]     divisor,
  output logic             nextSign,
  output logic             sign,
  output logic             zeroDiv,
  output logic             tooBig,
  output logic [W-1:0]     quotient,
  output logic [W-1:0]     remainder,
  output logic             divByZero,
  output logic             overflow
);
  localparam int AW = W + 1;

  logic [AW-1:0] accR;      // sign bit on top of the accumulator
  logic [W-1:0]  mqR;
  logic [W-1:0]  dvR;
  logic          dbzR, ovfR;

  logic [AW-1:0] shifted, extDiv, stepRes, fixRes;
  logic [W-1:0]  upperHalf;
  logic          errLoad;

  assign upperHalf = dividend[2*W-1:W];
  assign zeroDiv   = (divisor == '0);
  assign tooBig    = (upperHalf >= divisor);
  assign errLoad   = zeroDiv || tooBig;

  // One shift plus add or subtract, picked by the sign of the previous step
  assign shifted  = {accR[W-1:0], mqR[W-1]};
  assign extDiv   = {1'b0, dvR};
  assign stepRes  = accR[W] ? (shifted + extDiv) : (shifted - extDiv);
  assign fixRes   = accR + extDiv;
  assign nextSign = stepRes[W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR <= '0;
      mqR  <= '0;
      dvR  <= '0;
      dbzR <= 1'b0;
      ovfR <= 1'b0;
    end else if (strb.load) begin
      dvR  <= divisor;
      accR <= {1'b0, upperHalf};
      mqR  <= errLoad ? '1 : dividend[W-1:0];
      dbzR <= zeroDiv;
      ovfR <= tooBig && !zeroDiv;
    end else if (strb.step) begin
      accR <= stepRes;
      mqR  <= {mqR[W-2:0], ~stepRes[W]};
    end else if (strb.fix) begin
      accR <= fixRes;
    end
  end

  assign sign      = accR[W];
  assign quotient  = mqR;
  assign remainder = accR[W-1:0];
  assign divByZero = dbzR;
  assign overflow  = ovfR;

  AST_FIX_POSITIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.fix |=> !sign); // R2

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.step || strb.fix) |=>
      ($stable(mqR) && $stable(accR) && $stable(dbzR) && $stable(ovfR))); // R8

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(dbzR && ovfR)); // R4
endmodule

// File: rtl/nrdiv_control.sv
module nrdiv_control
  import nrdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        nextSign,
  input  logic        sign,
  input  logic        zeroDiv,
  input  logic        tooBig,
  output nrdivStrb_t  strb,
  output logic        done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  nrdivState_t stateR, stateNx;
  logic [CW-1:0] cntR;

  always_comb begin
    strb      = '0;
    strb.load = (stateR == ST_IDLE) && start;
    strb.step = (stateR == ST_RUN);
    strb.fix  = (stateR == ST_FIX);
  end

  always_comb begin
    stateNx = stateR;
    unique case (stateR)
      ST_IDLE: if (start) stateNx = (zeroDiv || tooBig) ? ST_FIN : ST_RUN;
      ST_RUN:  if (cntR == LAST) stateNx = nextSign ? ST_FIX : ST_FIN;
      ST_FIX:  stateNx = ST_FIN;
      ST_FIN:  stateNx = ST_IDLE;
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      cntR   <= '0;
    end else begin
      stateR <= stateNx;
      if (strb.load)      cntR <= '0;
      else if (strb.step) cntR <= cntR + 1'b1;
    end
  end

  assign done = (stateR == ST_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_FIX_ONLY_NEG: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == ST_FIX) |-> sign); // R5

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (stateR == ST_RUN) |-> (cntR < CW'(W))); // R5

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (stateR != ST_IDLE) |-> !strb.load); // R7
endmodule

// File: rtl/nr_divider.sv
module nr_divider
  import nrdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           done,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           divByZero,
  output logic           overflow
);
  nrdivStrb_t strb;
  logic nextSign, sign, zeroDiv, tooBig;

  nrdiv_control #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .nextSign(nextSign), .sign(sign), .zeroDiv(zeroDiv), .tooBig(tooBig),
    .strb(strb), .done(done)
  );

  nrdiv_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dividend(dividend), .divisor(divisor),
    .nextSign(nextSign), .sign(sign), .zeroDiv(zeroDiv), .tooBig(tooBig),
    .quotient(quotient), .remainder(remainder),
    .divByZero(divByZero), .overflow(overflow)
  );

  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    !(divByZero && overflow)); // R3
endmodule

// File: tb/test_nr_divider.sv
`timescale 1ns/1ps
module test_nr_divider;
  localparam int W = 8;
  localparam real CLK_PERIOD = 5.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2*W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic done, divByZero, overflow;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nr_divider #(.W(W)) i_nr_divider (
    .clk(clk), .rstN(rstN), .start(start),
    .dividend(dividend), .divisor(divisor),
    .done(done), .quotient(quotient), .remainder(remainder),
    .divByZero(divByZero), .overflow(overflow)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One division, optionally with a disturbing start pulse mid-run (R7)
  task automatic runDiv(input logic [2*W-1:0] dvd, input logic [W-1:0] dsr, input bit disturb);
    int lat;
    int expQ, expR, expLat;
    bit expDbz, expOvf;
    logic [W-1:0] upper;
    upper  = dvd[2*W-1:W];
    expDbz = (dsr == 0);
    expOvf = !expDbz && (upper >= dsr);
    if (expDbz || expOvf) begin
      expQ = (1 << W) - 1;
      expR = upper;
      expLat = 0;
    end else begin
      expQ = int'(dvd) / int'(dsr);
      expR = int'(dvd) % int'(dsr);
      expLat = (expQ % 2 == 1) ? W : W + 1;
    end
    @(negedge clk);
    dividend = dvd; divisor = dsr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      if (disturb && lat == 3) begin
        start = 1'b1; dividend = 16'h0011; divisor = 8'h03;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check("R5", "latency", lat, expLat);
    if (expDbz || expOvf) begin
      check(expDbz ? "R4" : "R3", "quotient", quotient, expQ);
      check(expDbz ? "R4" : "R3", "remainder", remainder, expR);
    end else begin
      check(disturb ? "R7" : "R2", "quotient", quotient, expQ);
      check(disturb ? "R7" : "R2", "remainder", remainder, expR);
    end
    check("R4", "divByZero", divByZero, expDbz);
    check("R3", "overflow", overflow, expOvf);
    @(negedge clk);
    check("R6", "done low after pulse", done, 0);
    repeat (3) @(negedge clk);
    check("R8", "quotient held", quotient, expQ);
    check("R8", "remainder held", remainder, expR);
    check("R8", "flags held", {divByZero, overflow}, {expDbz, expOvf});
  endtask

  task automatic testReset();
    check("R1", "done", done, 0);
    check("R1", "quotient", quotient, 0);
    check("R1", "remainder", remainder, 0);
    check("R1", "flags", {divByZero, overflow}, 0);
  endtask

  task automatic testBasic();
    runDiv(16'd7, 8'd2, 1'b0);        // q=3, odd, no correction
    runDiv(16'd12, 8'd3, 1'b0);       // q=4, even, correction
    runDiv(16'd0, 8'd5, 1'b0);
    runDiv(16'd100, 8'd1, 1'b0);
    runDiv(16'hFEFF, 8'hFF, 1'b0);    // largest legal
    runDiv(16'd1001, 8'd8, 1'b0);
  endtask

  task automatic testErrors();
    runDiv(16'h1234, 8'd0, 1'b0);     // R4
    runDiv(16'h0500, 8'd5, 1'b0);     // R3 equal boundary
    runDiv(16'hFF00, 8'h10, 1'b0);    // R3
  endtask

  task automatic testBusy();
    runDiv(16'h3A7C, 8'h5D, 1'b1);    // R7
  endtask

  task automatic testSweep();
    for (int d = 1; d < 256; d += 37) begin
      runDiv(16'((d * 211 + 13) % (d * 256)), 8'(d), 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testErrors();
    testBusy();
    testSweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule